// File: doc/BRIEF.md
# Ethernet DMA Controller Command and Interrupt Registers

This block is the 32-bit register file that software uses to run the DMA engines of an Ethernet MAC. It holds the command word, which enables transmit, enables receive, admits over-length frames, and can request a self-clearing soft reset. It also holds the word-aligned base addresses of the transmit and receive descriptor lists, an interrupt enable word and an interrupt status word, and read-back copies of the engines' current descriptor and buffer pointers. The management-port and address-match registers are kept here only as plain read/write storage that loads its reset values.

The transmit and receive engines report events as one-cycle pulses. Each pulse sets a sticky status bit. The upper status half drives a transmit interrupt line and the lower half drives a receive interrupt line, in both cases through the enable word. A write to one of two demand locations produces a one-cycle start strobe toward the matching engine. A soft reset returns every register to its reset value. While the soft reset runs, the block reports busy for a fixed window, and every read during that window returns zero.

Register word indices: 0 command, 1 interrupt enable, 2 interrupt status, 3 transmit list base, 4 receive list base, 5 transmit demand, 6 receive demand, 7 to 10 current pointers (transmit descriptor, transmit buffer, receive descriptor, receive buffer), and 11 to 17 plain storage (management data, management address, FIFO threshold, receive frame limit, missed-frame count, address-match control, address-match enable).

Top module: `emac_ctl_regs`

## Requirements
- R1: After the hardware reset, both list base words read 0xFFFFFFFC, management address reads 0x00900000, FIFO threshold reads 0x0101, receive frame limit reads 0x0800 and missed-frame count reads 0x7FFF. Every other index reads 0, and every output is low.
- R2: The command word keeps only bit 0 (receive on, drives `rx_on`), bit 1 (long frames admitted, drives `long_ok`) and bit 8 (transmit on, drives `tx_on`). Its other bits read 0.
- R3: A write to the command word with bit 24 set starts a soft reset. `srst_busy` is high for exactly SRST_CYC (16) cycles, starting the cycle after the write, and every read during that window returns 0.
- R4: After the soft reset window, every index reads its R1 reset value, command bit 24 reads 0, and both interrupt lines are low.
- R5: A pulse on `tx_evt[k]` sets status bit 16+k and a pulse on `rx_evt[k]` sets status bit k. Only bits 24, 23, 18, 16, 11, 10, 9, 8, 4, 3 and 0 exist. Every other status bit always reads 0.
- R6: Writing 1 to a status bit clears it. If an event sets a bit in the same cycle that a write clears it, the bit stays set.
- R7: The interrupt enable word stores only the R5 bit positions. Every other bit reads 0.
- R8: `irq_tx` is high when any status bit in 31:16 is set together with its enable bit. `irq_rx` does the same for bits 15:0. Each line changes in the cycle after the event or write that caused the change.
- R9: A write to index 5 (or 6) drives `tx_kick` (or `rx_kick`) high for exactly the next cycle. These indices store nothing and read 0.
- R10: The list base words store bits 31:2 and read 0 in bits 1:0. Their values appear on `tx_list_base` and `rx_list_base`.
- R11: An update strobe captures the engine's descriptor and buffer pointers into indices 7 to 10. Bus writes to those indices are ignored.
- R12: Indices 11 to 17 store all 32 written bits.
- R13: During the soft reset window, bus writes and engine events have no effect. Indices outside 0 to 17 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_idx | input | IDX_W | Register word index for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_idx` (combinational) |
| tx_evt | input | 16 | Transmit event pulses, setting status bits 31:16 |
| rx_evt | input | 16 | Receive event pulses, setting status bits 15:0 |
| tx_ptr_upd | input | 1 | Capture strobe for the transmit pointers |
| tx_desc_ptr | input | 32 | Current transmit descriptor address |
| tx_buf_ptr | input | 32 | Current transmit buffer address |
| rx_ptr_upd | input | 1 | Capture strobe for the receive pointers |
| rx_desc_ptr | input | 32 | Current receive descriptor address |
| rx_buf_ptr | input | 32 | Current receive buffer address |
| tx_on | output | 1 | Transmit engine enabled |
| rx_on | output | 1 | Receive engine enabled |
| long_ok | output | 1 | Over-length frames admitted |
| tx_list_base | output | 32 | Transmit descriptor list base |
| rx_list_base | output | 32 | Receive descriptor list base |
| tx_kick | output | 1 | Transmit start-demand strobe |
| rx_kick | output | 1 | Receive start-demand strobe |
| srst_busy | output | 1 | Soft reset window active |
| irq_tx | output | 1 | Transmit interrupt line |
| irq_rx | output | 1 | Receive interrupt line |

## Verification
The case where two functions fall in the same cycle is a write-one-to-clear to the status word landing in the same cycle as an engine event on the same bit. The bench provokes it by holding `tx_evt[2]` high during the write that clears bits 18 and 4. It then requires bit 18 to stay set while bit 4, which had no event, clears. A second overlap puts a bus write and a full set of event pulses inside the soft reset window. The bench judges it by the reset values that read back once the window ends.

// File: rtl/emac_ctl_pkg.sv
package emac_ctl_pkg;

    typedef logic [31:0] word_t;

    // Register word indices
    localparam int IX_CMD    = 0;
    localparam int IX_IEN    = 1;
    localparam int IX_ISTAT  = 2;
    localparam int IX_TXBASE = 3;
    localparam int IX_RXBASE = 4;
    localparam int IX_TXKICK = 5;
    localparam int IX_RXKICK = 6;
    localparam int IX_TXCD   = 7;
    localparam int IX_TXCB   = 8;
    localparam int IX_RXCD   = 9;
    localparam int IX_RXCB   = 10;
    localparam int IX_PLAIN0 = 11;
    localparam int NUM_PLAIN = 7;

    // Command bits
    localparam int CMD_RXEN = 0;
    localparam int CMD_LONG = 1;
    localparam int CMD_TXEN = 8;
    localparam int CMD_SRST = 24;
    localparam word_t CMD_KEEP = (32'd1 << CMD_RXEN) | (32'd1 << CMD_LONG) | (32'd1 << CMD_TXEN);

    // Implemented status / enable bit positions
    localparam int NUM_STAT_BITS = 11;
    localparam int STAT_POS [NUM_STAT_BITS] = '{24, 23, 18, 16, 11, 10, 9, 8, 4, 3, 0};

    function automatic word_t stat_mask_calc();
        word_t m;
        m = '0;
        for (int k = 0; k < NUM_STAT_BITS; k++) begin
            m[STAT_POS[k]] = 1'b1;
        end
        return m;
    endfunction

    localparam word_t STAT_MASK = stat_mask_calc();

    localparam word_t BASE_RST  = 32'hFFFF_FFFC;
    localparam word_t BASE_KEEP = 32'hFFFF_FFFC;

    // Reset value of each plain storage register
    function automatic word_t plain_rst(int k);
        case (k)
            1:       return 32'h0090_0000;
            2:       return 32'h0000_0101;
            3:       return 32'h0000_0800;
            4:       return 32'h0000_7FFF;
            default: return 32'h0000_0000;
        endcase
    endfunction

endpackage

// File: rtl/emac_srst_seq.sv
module emac_srst_seq #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CNT_W'(CYCLES - 1);
        end else if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;

endmodule

// File: rtl/emac_irq_stat.sv
module emac_irq_stat
    import emac_ctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        blk,
    input  logic        stat_we,
    input  logic        ien_we,
    input  word_t       wdata,
    input  logic [15:0] tx_evt,
    input  logic [15:0] rx_evt,
    output word_t       stat_o,
    output word_t       ien_o,
    output logic        irq_tx,
    output logic        irq_rx
);
    typedef struct packed {
        word_t stat;
        word_t ien;
    } irq_t;

    irq_t  st_d, st_q;
    word_t set_v;
    word_t clr_v;

    always_comb begin
        st_d  = st_q;
        set_v = blk ? '0 : ({tx_evt, rx_evt} & STAT_MASK);
        clr_v = stat_we ? wdata : '0;
        if (clr) begin
            st_d = '0;
        end else begin
            if (ien_we) begin
                st_d.ien = wdata & STAT_MASK;
            end
            // an event landing with a clear keeps the bit set
            st_d.stat = ((st_q.stat & ~clr_v) | set_v) & STAT_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o = st_q.stat;
    assign ien_o  = st_q.ien;
    assign irq_tx = |(st_q.stat[31:16] & st_q.ien[31:16]);
    assign irq_rx = |(st_q.stat[15:0]  & st_q.ien[15:0]);

endmodule

// File: rtl/emac_cfg_store.sv
module emac_cfg_store
    import emac_ctl_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             blk,
    input  logic             wr_ok,
    input  logic [IDX_W-1:0] idx,
    input  word_t            wdata,
    input  logic             tx_upd,
    input  word_t            tx_desc,
    input  word_t            tx_buf,
    input  logic             rx_upd,
    input  word_t            rx_desc,
    input  word_t            rx_buf,
    output word_t            cmd_o,
    output word_t            tx_base_o,
    output word_t            rx_base_o,
    output logic             tx_kick_o,
    output logic             rx_kick_o,
    output word_t            tx_cd_o,
    output word_t            tx_cb_o,
    output word_t            rx_cd_o,
    output word_t            rx_cb_o,
    output word_t            plain_o [NUM_PLAIN]
);
    typedef struct packed {
        word_t                       cmd;
        word_t                       tx_base;
        word_t                       rx_base;
        word_t                       tx_cd;
        word_t                       tx_cb;
        word_t                       rx_cd;
        word_t                       rx_cb;
        logic [NUM_PLAIN-1:0][31:0]  plain;
        logic                        tx_kick;
        logic                        rx_kick;
    } store_t;

    function automatic store_t store_rst();
        store_t s;
        s         = '0;
        s.tx_base = BASE_RST;
        s.rx_base = BASE_RST;
        for (int k = 0; k < NUM_PLAIN; k++) begin
            s.plain[k] = plain_rst(k);
        end
        return s;
    endfunction

    localparam store_t ST_RST = store_rst();

    store_t               st_d, st_q;
    logic [NUM_PLAIN-1:0] plain_hit;

    for (genvar g = 0; g < NUM_PLAIN; g++) begin : g_plain
        assign plain_hit[g] = wr_ok && (idx == IDX_W'(IX_PLAIN0 + g));
        assign plain_o[g]   = st_q.plain[g];
    end

    always_comb begin
        st_d         = st_q;
        st_d.tx_kick = wr_ok && (idx == IDX_W'(IX_TXKICK));
        st_d.rx_kick = wr_ok && (idx == IDX_W'(IX_RXKICK));
        if (clr) begin
            st_d = ST_RST;
        end else begin
            if (wr_ok && idx == IDX_W'(IX_CMD)) begin
                st_d.cmd = wdata & CMD_KEEP;
            end
            if (wr_ok && idx == IDX_W'(IX_TXBASE)) begin
                st_d.tx_base = wdata & BASE_KEEP;
            end
            if (wr_ok && idx == IDX_W'(IX_RXBASE)) begin
                st_d.rx_base = wdata & BASE_KEEP;
            end
            for (int k = 0; k < NUM_PLAIN; k++) begin
                if (plain_hit[k]) begin
                    st_d.plain[k] = wdata;
                end
            end
            if (tx_upd && !blk) begin
                st_d.tx_cd = tx_desc;
                st_d.tx_cb = tx_buf;
            end
            if (rx_upd && !blk) begin
                st_d.rx_cd = rx_desc;
                st_d.rx_cb = rx_buf;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_o     = st_q.cmd;
    assign tx_base_o = st_q.tx_base;
    assign rx_base_o = st_q.rx_base;
    assign tx_kick_o = st_q.tx_kick;
    assign rx_kick_o = st_q.rx_kick;
    assign tx_cd_o   = st_q.tx_cd;
    assign tx_cb_o   = st_q.tx_cb;
    assign rx_cd_o   = st_q.rx_cd;
    assign rx_cb_o   = st_q.rx_cb;

endmodule

// File: rtl/emac_ctl_regs.sv
module emac_ctl_regs
    import emac_ctl_pkg::*;
#(
    parameter int IDX_W    = 5,
    parameter int SRST_CYC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [15:0]      tx_evt,
    input  logic [15:0]      rx_evt,
    input  logic             tx_ptr_upd,
    input  logic [31:0]      tx_desc_ptr,
    input  logic [31:0]      tx_buf_ptr,
    input  logic             rx_ptr_upd,
    input  logic [31:0]      rx_desc_ptr,
    input  logic [31:0]      rx_buf_ptr,
    output logic             tx_on,
    output logic             rx_on,
    output logic             long_ok,
    output logic [31:0]      tx_list_base,
    output logic [31:0]      rx_list_base,
    output logic             tx_kick,
    output logic             rx_kick,
    output logic             srst_busy,
    output logic             irq_tx,
    output logic             irq_rx
);
    logic  wr_ok;
    logic  srst_go;
    word_t cmd_w, stat_w, ien_w;
    word_t tx_cd_w, tx_cb_w, rx_cd_w, rx_cb_w;
    word_t plain_w [NUM_PLAIN];
    word_t rd_d;

    assign wr_ok   = reg_we && !srst_busy;
    assign srst_go = wr_ok && (reg_idx == IDX_W'(IX_CMD)) && reg_wdata[CMD_SRST];

    emac_srst_seq #(.CYCLES(SRST_CYC)) u_srst (
        .clk   (clk),
        .rst_n (rst_n),
        .start (srst_go),
        .busy  (srst_busy)
    );

    emac_irq_stat u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (srst_go),
        .blk     (srst_busy),
        .stat_we (wr_ok && reg_idx == IDX_W'(IX_ISTAT)),
        .ien_we  (wr_ok && reg_idx == IDX_W'(IX_IEN)),
        .wdata   (reg_wdata),
        .tx_evt  (tx_evt),
        .rx_evt  (rx_evt),
        .stat_o  (stat_w),
        .ien_o   (ien_w),
        .irq_tx  (irq_tx),
        .irq_rx  (irq_rx)
    );

    emac_cfg_store #(.IDX_W(IDX_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (srst_go),
        .blk       (srst_busy),
        .wr_ok     (wr_ok),
        .idx       (reg_idx),
        .wdata     (reg_wdata),
        .tx_upd    (tx_ptr_upd),
        .tx_desc   (tx_desc_ptr),
        .tx_buf    (tx_buf_ptr),
        .rx_upd    (rx_ptr_upd),
        .rx_desc   (rx_desc_ptr),
        .rx_buf    (rx_buf_ptr),
        .cmd_o     (cmd_w),
        .tx_base_o (tx_list_base),
        .rx_base_o (rx_list_base),
        .tx_kick_o (tx_kick),
        .rx_kick_o (rx_kick),
        .tx_cd_o   (tx_cd_w),
        .tx_cb_o   (tx_cb_w),
        .rx_cd_o   (rx_cd_w),
        .rx_cb_o   (rx_cb_w),
        .plain_o   (plain_w)
    );

    always_comb begin
        rd_d = '0;
        case (reg_idx)
            IDX_W'(IX_CMD):    rd_d = cmd_w;
            IDX_W'(IX_IEN):    rd_d = ien_w;
            IDX_W'(IX_ISTAT):  rd_d = stat_w;
            IDX_W'(IX_TXBASE): rd_d = tx_list_base;
            IDX_W'(IX_RXBASE): rd_d = rx_list_base;
            IDX_W'(IX_TXCD):   rd_d = tx_cd_w;
            IDX_W'(IX_TXCB):   rd_d = tx_cb_w;
            IDX_W'(IX_RXCD):   rd_d = rx_cd_w;
            IDX_W'(IX_RXCB):   rd_d = rx_cb_w;
            default: begin
                for (int k = 0; k < NUM_PLAIN; k++) begin
                    if (reg_idx == IDX_W'(IX_PLAIN0 + k)) begin
                        rd_d = plain_w[k];
                    end
                end
            end
        endcase
    end

    assign reg_rdata = srst_busy ? '0 : rd_d;
    assign tx_on     = cmd_w[CMD_TXEN];
    assign rx_on     = cmd_w[CMD_RXEN];
    assign long_ok   = cmd_w[CMD_LONG];

endmodule

// File: rtl/emac_ctl_regs_chk.sv
module emac_ctl_regs_chk
    import emac_ctl_pkg::*;
#(
    parameter int IDX_W    = 5,
    parameter int SRST_CYC = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic [IDX_W-1:0] reg_idx,
    input logic [31:0]      reg_wdata,
    input logic [31:0]      reg_rdata,
    input logic [15:0]      rx_evt,
    input logic             tx_kick,
    input logic             rx_kick,
    input logic             srst_busy,
    input logic             irq_tx,
    input logic             irq_rx,
    input logic             tx_on,
    input logic             rx_on,
    input logic [31:0]      stat,
    input logic             srst_go
);
    int unsigned busy_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_len_q <= 0;
        end else begin
            busy_len_q <= srst_busy ? busy_len_q + 1 : 0;
        end
    end

    // R3
    srst_zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst_busy |-> (reg_rdata == 32'd0));

    // R3
    srst_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(srst_busy) |-> $past(reg_we && reg_idx == IDX_W'(IX_CMD) && reg_wdata[CMD_SRST] && !srst_busy));

    // R3
    srst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(srst_busy) |-> (busy_len_q == SRST_CYC));

    // R4
    srst_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(srst_busy) |-> (!tx_on && !rx_on && !irq_tx && !irq_rx));

    // R5
    stat_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat & ~STAT_MASK) == 32'd0);

    // R6
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_evt[4] && !srst_busy && !srst_go) |=> stat[4]);

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst_busy |-> (!irq_tx && !irq_rx));

    // R9
    tx_kick_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_kick |-> $past(reg_we && reg_idx == IDX_W'(IX_TXKICK) && !srst_busy));

    // R9
    rx_kick_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_kick |-> $past(reg_we && reg_idx == IDX_W'(IX_RXKICK) && !srst_busy));

endmodule

bind emac_ctl_regs emac_ctl_regs_chk #(.IDX_W(IDX_W), .SRST_CYC(SRST_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_idx   (reg_idx),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .rx_evt    (rx_evt),
    .tx_kick   (tx_kick),
    .rx_kick   (rx_kick),
    .srst_busy (srst_busy),
    .irq_tx    (irq_tx),
    .irq_rx    (irq_rx),
    .tx_on     (tx_on),
    .rx_on     (rx_on),
    .stat      (stat_w),
    .srst_go   (srst_go)
);

// File: tb/sim_emac_ctl_regs.sv
module sim_emac_ctl_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] tx_evt = '0;
    logic [15:0] rx_evt = '0;
    logic        tx_ptr_upd = 1'b0;
    logic [31:0] tx_desc_ptr = '0;
    logic [31:0] tx_buf_ptr = '0;
    logic        rx_ptr_upd = 1'b0;
    logic [31:0] rx_desc_ptr = '0;
    logic [31:0] rx_buf_ptr = '0;
    logic        tx_on, rx_on, long_ok, tx_kick, rx_kick, srst_busy, irq_tx, irq_rx;
    logic [31:0] tx_list_base, rx_list_base;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    emac_ctl_regs u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_evt(tx_evt), .rx_evt(rx_evt),
        .tx_ptr_upd(tx_ptr_upd), .tx_desc_ptr(tx_desc_ptr), .tx_buf_ptr(tx_buf_ptr),
        .rx_ptr_upd(rx_ptr_upd), .rx_desc_ptr(rx_desc_ptr), .rx_buf_ptr(rx_buf_ptr),
        .tx_on(tx_on), .rx_on(rx_on), .long_ok(long_ok),
        .tx_list_base(tx_list_base), .rx_list_base(rx_list_base),
        .tx_kick(tx_kick), .rx_kick(rx_kick), .srst_busy(srst_busy),
        .irq_tx(irq_tx), .irq_rx(irq_rx)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [4:0]  idx;
        logic [31:0] wd;
        logic [31:0] ex;
    } vec_t;

    localparam int NVEC = 17;
    localparam vec_t VEC [NVEC] = '{
        '{4'd2,  5'd0,  32'h0000_0103, 32'h0000_0103},
        '{4'd2,  5'd0,  32'hF0EF_FEFC, 32'h0000_0000},
        '{4'd2,  5'd0,  32'h0000_0101, 32'h0000_0101},
        '{4'd10, 5'd3,  32'h1234_5677, 32'h1234_5674},
        '{4'd10, 5'd4,  32'hA5A5_A5A7, 32'hA5A5_A5A4},
        '{4'd7,  5'd1,  32'hFFFF_FFFF, 32'h0185_0F19},
        '{4'd7,  5'd1,  32'h0000_0000, 32'h0000_0000},
        '{4'd12, 5'd11, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
        '{4'd12, 5'd12, 32'h0000_0000, 32'h0000_0000},
        '{4'd12, 5'd13, 32'h0000_3303, 32'h0000_3303},
        '{4'd12, 5'd14, 32'h0000_05EE, 32'h0000_05EE},
        '{4'd12, 5'd15, 32'h0000_0001, 32'h0000_0001},
        '{4'd12, 5'd16, 32'h0000_0013, 32'h0000_0013},
        '{4'd12, 5'd17, 32'h0000_FFFF, 32'h0000_FFFF},
        '{4'd11, 5'd7,  32'hFFFF_FFFF, 32'h0000_0000},
        '{4'd9,  5'd5,  32'h0000_0001, 32'h0000_0000},
        '{4'd13, 5'd31, 32'hFFFF_FFFF, 32'h0000_0000}
    };

    function automatic logic [31:0] exp_rst(input int i);
        case (i)
            3, 4:    return 32'hFFFF_FFFC;
            12:      return 32'h0090_0000;
            13:      return 32'h0000_0101;
            14:      return 32'h0000_0800;
            15:      return 32'h0000_7FFF;
            default: return 32'h0000_0000;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] i, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_idx = i; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] i, output logic [31:0] d);
        reg_idx = i;
        #1;
        d = reg_rdata;
    endtask

    task automatic evt(input logic [15:0] t, input logic [15:0] r);
        @(negedge clk);
        tx_evt = t; rx_evt = r;
        @(negedge clk);
        tx_evt = '0; rx_evt = '0;
    endtask

    task automatic chk_all_rst(input string tag);
        logic [31:0] v;
        int bad;
        bad = 0;
        for (int i = 0; i < 18; i++) begin
            rd(5'(i), v);
            if (v !== exp_rst(i)) begin
                bad++;
                $display("  index %0d reads %h", i, v);
            end
        end
        chk(tag, 32'(bad), 32'd0);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int n, bad;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_all_rst("R1 reset values");
        chk("R1 outputs idle", {26'd0, tx_on, rx_on, long_ok, srst_busy, irq_tx, irq_rx}, 32'd0);

        // table of write/readback vectors (R2 R7 R9 R10 R11 R12 R13)
        for (int k = 0; k < NVEC; k++) begin
            wr(VEC[k].idx, VEC[k].wd);
            rd(VEC[k].idx, v);
            n_run++;
            if (v !== VEC[k].ex) begin
                n_fail++;
                $display("FAIL R%0d vector %0d: actual %h expected %h", VEC[k].req, k, v, VEC[k].ex);
            end
        end
        // R2 command outputs after last command vector 0x101
        chk("R2 enable outputs", {29'd0, tx_on, rx_on, long_ok}, 32'h6);
        // R10 base outputs
        chk("R10 tx base out", tx_list_base, 32'h1234_5674);
        chk("R10 rx base out", rx_list_base, 32'hA5A5_A5A4);

        // R9 kick strobes last exactly one cycle
        wr(5'd5, 32'd0);
        chk("R9 tx kick pulse", {30'd0, tx_kick, rx_kick}, 32'h2);
        @(negedge clk);
        chk("R9 tx kick ends", {30'd0, tx_kick, rx_kick}, 32'h0);
        wr(5'd6, 32'd0);
        chk("R9 rx kick pulse", {30'd0, tx_kick, rx_kick}, 32'h1);
        @(negedge clk);
        chk("R9 rx kick ends", {30'd0, tx_kick, rx_kick}, 32'h0);

        // R5 all events, only implemented bits set
        evt(16'hFFFF, 16'hFFFF);
        rd(5'd2, v);
        chk("R5 status set", v, 32'h0185_0F19);
        chk("R8 no irq when disabled", {30'd0, irq_tx, irq_rx}, 32'd0);

        // R6 clear the transmit half
        wr(5'd2, 32'hFFFF_0000);
        rd(5'd2, v);
        chk("R6 w1c upper half", v, 32'h0000_0F19);

        // R8 interrupt lines
        wr(5'd1, 32'h0001_0000);
        chk("R8 tx line low before event", {31'd0, irq_tx}, 32'd0);
        evt(16'h0001, 16'h0000);
        chk("R8 tx line from bit16", {30'd0, irq_tx, irq_rx}, 32'h2);
        wr(5'd1, 32'h0001_0001);
        chk("R8 rx line from bit0", {30'd0, irq_tx, irq_rx}, 32'h3);
        wr(5'd2, 32'h0000_0001);
        chk("R8 rx line drops on clear", {30'd0, irq_tx, irq_rx}, 32'h2);

        // R6 event and clear in the same cycle
        evt(16'h0004, 16'h0000);
        @(negedge clk);
        reg_we = 1'b1; reg_idx = 5'd2; reg_wdata = 32'h0004_0010; tx_evt = 16'h0004;
        @(negedge clk);
        reg_we = 1'b0; tx_evt = '0;
        rd(5'd2, v);
        chk("R6 event beats clear", v, 32'h0005_0F08);

        // R11 pointer capture, writes ignored
        @(negedge clk);
        tx_ptr_upd = 1'b1; tx_desc_ptr = 32'h1000_0040; tx_buf_ptr = 32'h2000_0000;
        rx_ptr_upd = 1'b1; rx_desc_ptr = 32'h1000_0080; rx_buf_ptr = 32'h3000_0004;
        @(negedge clk);
        tx_ptr_upd = 1'b0; rx_ptr_upd = 1'b0;
        rd(5'd7, v);  chk("R11 tx desc ptr", v, 32'h1000_0040);
        rd(5'd8, v);  chk("R11 tx buf ptr", v, 32'h2000_0000);
        rd(5'd9, v);  chk("R11 rx desc ptr", v, 32'h1000_0080);
        rd(5'd10, v); chk("R11 rx buf ptr", v, 32'h3000_0004);
        wr(5'd9, 32'h0);
        rd(5'd9, v);  chk("R11 write ignored", v, 32'h1000_0080);

        // R3 soft reset window
        wr(5'd0, 32'h0100_0103);
        chk("R3 busy after request", {31'd0, srst_busy}, 32'h1);
        n = 0; bad = 0;
        while (srst_busy === 1'b1 && n < 40) begin
            n++;
            rd(5'd15, v);
            if (v !== 32'd0) bad++;
            if (n == 3) begin
                // R13 write and events inside the window
                reg_we = 1'b1; reg_idx = 5'd13; reg_wdata = 32'h0000_AAAA;
                tx_evt = '1; rx_evt = '1;
            end else begin
                reg_we = 1'b0; tx_evt = '0; rx_evt = '0;
            end
            @(negedge clk);
        end
        reg_we = 1'b0; tx_evt = '0; rx_evt = '0;
        chk("R3 window length", 32'(n), 32'd16);
        chk("R3 reads zero in window", 32'(bad), 32'd0);

        // R4 R13 state after the window
        chk_all_rst("R4 R13 values after soft reset");
        chk("R4 outputs idle after soft reset", {27'd0, tx_on, rx_on, long_ok, irq_tx, irq_rx}, 32'd0);

        finish_run();
    end

endmodule